// File: doc/BRIEF.md
# Sticky Wide Right Shifter

This block takes a 192-bit fixed-point quantity made of three 64-bit words (upper, middle, low), with the binary point between the middle and the low word. It shifts the quantity right by an unsigned count. The result is two integer words and one extra word that carries the fraction in a form ready for a later rounding step.

The extra word keeps the most recent bits to leave the integer part. The MSB of the extra word is always the last bit shifted out of the integer part. Bits that fall further down are not kept. Their presence is folded into a single sticky flag, which is ORed into bit 0 of the extra word. Any count, up to the largest the count port can carry, gives a defined result.

The datapath is combinational. An output register stage is on by default and adds one clock of latency. Rounding and exponent handling are left to the surrounding logic.

Top module: `sticky_wide_rshift`

## Requirements
- R1: With a count of 0, the three outputs equal the upper, middle and low input words unchanged. No sticky bit is added, even when the low word is nonzero.
- R2: For counts c from 1 to 63, the integer high word is upper>>c. The integer low word holds the c bits that leave the upper word, above middle>>c. The extra word holds the c bits that leave the middle word, in its top c positions, and is zero below them apart from the sticky bit.
- R3: At a count of 64, the integer high word is 0 and the integer low word is the upper word. The extra word is the middle word with bit 0 ORed with 1 whenever the low word is nonzero.
- R4: For counts c from 65 to 127, the integer high word is 0 and the integer low word is upper>>(c-64). The extra word holds, in its top (c-64) positions, the bits that leave the upper word. All middle-word bits go to the sticky flag only.
- R5: At a count of 128, both integer words are 0. The extra word is the upper word with bit 0 ORed with the sticky flag, which is set when the middle or low word is nonzero.
- R6: For any count above 128, both integer words are 0, extra bits 63..1 are 0, and extra bit 0 is 1 exactly when any bit of the three input words is 1.
- R7: The sticky flag is set when a discarded source word holds a 1: the low word for any nonzero count, the middle word for counts above 64, and the upper word for counts above 128. It acts on bit 0 of the extra word only; bits 63..1 keep their shifted values.
- R8: The count is unsigned, and every value of the 16-bit count is legal, including the maximum 65535.
- R9: With the default output register stage, each result appears on the outputs one clock after its inputs are sampled. While reset is held, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| word_hi | input | 64 | Upper word of the fixed-point input |
| word_mid | input | 64 | Middle word; lowest integer word of the input |
| word_lo | input | 64 | Low word; fraction part of the input |
| shift_amt | input | 16 | Unsigned right-shift count |
| res_hi | output | 64 | Upper integer word of the result |
| res_lo | output | 64 | Lower integer word of the result |
| res_extra | output | 64 | Fraction word: last bit shifted out at the MSB, sticky flag ORed into bit 0 |

## Verification
The hardest cases to reach are those where the sticky flag is the only thing that tells a correct design from a broken one. In these cases a single set bit sits in a discarded word, while the extra word it would be ORed into already ends in 0. Examples are a low word of 0x10 at a count of 1, a middle word with only a high bit set at a count of 100, and an upper word of 0x2 at a count of 129. The directed tasks place single-bit patterns at exactly these counts and at the region edges 63/64/65 and 127/128/129. A 256-bit reference shift, with the discarded bits rebuilt and compared, gives the expected value for every pattern. Random values over counts up to 300 and the full 16-bit range come after that.

// File: rtl/swrs_pkg.sv
package swrs_pkg;
  localparam int unsigned SWRS_WORD_W = 64;
  localparam int unsigned SWRS_CNT_W  = 16;
  localparam int unsigned SWRS_LANES  = 3;

  // number of zero words placed above the upper input word in the word stream
  localparam int unsigned SWRS_PAD = 4;
endpackage

// File: rtl/swrs_funnel.sv
module swrs_funnel #(
  parameter int unsigned W  = 64,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  hi_word,
  input  logic [W-1:0]  lo_word,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  res
);
  localparam int unsigned DW = 2 * W;

  logic [DW-1:0] stg [SW+1];

  assign stg[0] = {hi_word, lo_word};

  // logarithmic barrel: stage s moves the pair right by 2**s when amt[s] is set
  for (genvar s = 0; s < SW; s++) begin : g_stage
    assign stg[s+1] = amt[s] ? (stg[s] >> (2 ** s)) : stg[s];
  end

  assign res = stg[SW][W-1:0];
endmodule

// File: rtl/swrs_core.sv
module swrs_core
  import swrs_pkg::*;
#(
  parameter int unsigned W  = SWRS_WORD_W,
  parameter int unsigned CW = SWRS_CNT_W
) (
  input  logic [W-1:0]  up_w,
  input  logic [W-1:0]  mid_w,
  input  logic [W-1:0]  low_w,
  input  logic [CW-1:0] cnt,
  output logic [W-1:0]  z_hi,
  output logic [W-1:0]  z_lo,
  output logic [W-1:0]  z_ex
);
  localparam int unsigned KW    = $clog2(W);
  localparam int unsigned LANES = SWRS_LANES;
  localparam int unsigned EXTN  = SWRS_PAD + 3;

  logic [KW-1:0] k_bits;
  logic [CW-1:0] quo;
  logic [1:0]    wsel;
  logic          sticky;
  logic [W-1:0]  ext [EXTN];
  logic [LANES*W-1:0] lane_flat;

  assign k_bits = cnt[KW-1:0];
  assign quo    = cnt >> KW;
  // whole-word displacement; 3 and above leaves only zero words in every lane
  assign wsel   = (quo > CW'(2)) ? 2'd3 : quo[1:0];

  always_comb begin
    for (int i = 0; i < EXTN; i++) ext[i] = '0;
    ext[SWRS_PAD]     = up_w;
    ext[SWRS_PAD + 1] = mid_w;
    ext[SWRS_PAD + 2] = low_w;
  end

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    logic [W-1:0] hi_sel;
    logic [W-1:0] lo_sel;
    logic [W-1:0] out_w;

    always_comb begin
      hi_sel = ext[3'(SWRS_PAD - 1 + L) - {1'b0, wsel}];
      lo_sel = ext[3'(SWRS_PAD + L) - {1'b0, wsel}];
      // the fraction lane keeps only bits from one source word
      if ((L == LANES - 1) && (k_bits != '0)) lo_sel = '0;
    end

    swrs_funnel #(.W(W), .SW(KW)) u_funnel (
      .hi_word (hi_sel),
      .lo_word (lo_sel),
      .amt     (k_bits),
      .res     (out_w)
    );

    assign lane_flat[L*W +: W] = out_w;
  end

  always_comb begin
    sticky = 1'b0;
    if ((cnt != '0) && (low_w != '0))          sticky = 1'b1;
    if ((cnt > CW'(W)) && (mid_w != '0))       sticky = 1'b1;
    if ((cnt > CW'(2 * W)) && (up_w != '0))    sticky = 1'b1;
  end

  assign z_hi = lane_flat[0 +: W];
  assign z_lo = lane_flat[W +: W];
  assign z_ex = lane_flat[2*W +: W] | {{(W-1){1'b0}}, sticky};
endmodule

// File: rtl/swrs_rst_sync.sv
module swrs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/swrs_stage.sv
module swrs_stage #(
  parameter int unsigned W       = 64,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d_hi,
  input  logic [W-1:0] d_lo,
  input  logic [W-1:0] d_ex,
  output logic [W-1:0] q_hi,
  output logic [W-1:0] q_lo,
  output logic [W-1:0] q_ex
);
  if (REG_OUT) begin : g_reg
    logic [W-1:0] hi_q, lo_q, ex_q;
    logic [W-1:0] hi_n, lo_n, ex_n;

    always_comb begin
      hi_n = hi_q;
      lo_n = lo_q;
      ex_n = ex_q;
      if (load_en) begin
        hi_n = d_hi;
        lo_n = d_lo;
        ex_n = d_ex;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= '0;
        lo_q <= '0;
        ex_q <= '0;
      end else begin
        hi_q <= hi_n;
        lo_q <= lo_n;
        ex_q <= ex_n;
      end
    end

    assign q_hi = hi_q;
    assign q_lo = lo_q;
    assign q_ex = ex_q;
  end else begin : g_wire
    assign q_hi = d_hi;
    assign q_lo = d_lo;
    assign q_ex = d_ex;
  end
endmodule

// File: rtl/sticky_wide_rshift.sv
module sticky_wide_rshift
  import swrs_pkg::*;
#(
  parameter int unsigned W       = SWRS_WORD_W,
  parameter int unsigned CW      = SWRS_CNT_W,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  word_hi,
  input  logic [W-1:0]  word_mid,
  input  logic [W-1:0]  word_lo,
  input  logic [CW-1:0] shift_amt,
  output logic [W-1:0]  res_hi,
  output logic [W-1:0]  res_lo,
  output logic [W-1:0]  res_extra
);
  logic         rst_sync_n;
  logic [W-1:0] c_hi, c_lo, c_ex;

  swrs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  swrs_core #(.W(W), .CW(CW)) u_core (
    .up_w  (word_hi),
    .mid_w (word_mid),
    .low_w (word_lo),
    .cnt   (shift_amt),
    .z_hi  (c_hi),
    .z_lo  (c_lo),
    .z_ex  (c_ex)
  );

  swrs_stage #(.W(W), .REG_OUT(REG_OUT)) u_stage (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (1'b1),
    .d_hi    (c_hi),
    .d_lo    (c_lo),
    .d_ex    (c_ex),
    .q_hi    (res_hi),
    .q_lo    (res_lo),
    .q_ex    (res_extra)
  );
endmodule

// File: rtl/swrs_checker.sv
module swrs_checker #(
  parameter int unsigned W       = 64,
  parameter int unsigned CW      = 16,
  parameter bit          REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  word_hi,
  input logic [W-1:0]  word_mid,
  input logic [W-1:0]  word_lo,
  input logic [CW-1:0] shift_amt,
  input logic [W-1:0]  res_hi,
  input logic [W-1:0]  res_lo,
  input logic [W-1:0]  res_extra
);
  logic          primed;
  logic [W-1:0]  cap_hi, cap_mid, cap_lo;
  logic [CW-1:0] cap_cnt;
  logic [W-1:0]  s_hi, s_mid, s_lo;
  logic [CW-1:0] s_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed  <= 1'b0;
      cap_hi  <= '0;
      cap_mid <= '0;
      cap_lo  <= '0;
      cap_cnt <= '0;
    end else begin
      primed  <= 1'b1;
      cap_hi  <= word_hi;
      cap_mid <= word_mid;
      cap_lo  <= word_lo;
      cap_cnt <= shift_amt;
    end
  end

  if (REG_OUT) begin : g_lat
    assign s_hi = cap_hi;  assign s_mid = cap_mid;
    assign s_lo = cap_lo;  assign s_cnt = cap_cnt;
  end else begin : g_comb
    assign s_hi = word_hi; assign s_mid = word_mid;
    assign s_lo = word_lo; assign s_cnt = shift_amt;
  end

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && s_cnt == '0) |-> (res_hi == s_hi && res_lo == s_mid && res_extra == s_lo)); // R1

  AST_WORD_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && s_cnt == CW'(W)) |->
      (res_hi == '0 && res_lo == s_hi && res_extra == (s_mid | {{(W-1){1'b0}}, (s_lo != '0)}))); // R3

  AST_HI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && s_cnt >= CW'(W)) |-> (res_hi == '0)); // R4

  AST_DOUBLE_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && s_cnt == CW'(2*W)) |->
      (res_lo == '0 && res_extra == (s_hi | {{(W-1){1'b0}}, ((s_mid | s_lo) != '0)}))); // R5

  AST_FAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && s_cnt > CW'(2*W)) |->
      (res_lo == '0 && res_extra[W-1:1] == '0 &&
       res_extra[0] == ((s_hi | s_mid | s_lo) != '0))); // R6

  AST_STICKY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && s_cnt != '0 && s_lo != '0) |-> res_extra[0]); // R7
endmodule

bind sticky_wide_rshift swrs_checker #(.W(W), .CW(CW), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .word_hi   (word_hi),
  .word_mid  (word_mid),
  .word_lo   (word_lo),
  .shift_amt (shift_amt),
  .res_hi    (res_hi),
  .res_lo    (res_lo),
  .res_extra (res_extra)
);

// File: tb/sticky_wide_rshift_test.sv
module sticky_wide_rshift_test;
  logic        clk;
  logic        rst_n;
  logic [63:0] word_hi, word_mid, word_lo;
  logic [15:0] shift_amt;
  logic [63:0] res_hi, res_lo, res_extra;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  sticky_wide_rshift uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_hi   (word_hi),
    .word_mid  (word_mid),
    .word_lo   (word_lo),
    .shift_amt (shift_amt),
    .res_hi    (res_hi),
    .res_lo    (res_lo),
    .res_extra (res_extra)
  );

  always #10 clk = ~clk;

  // reference: 256-bit shift, fraction window masked to one source word,
  // discarded bits found by shifting the kept bits back and comparing
  function automatic void ref_model(input logic [63:0] a0, input logic [63:0] a1,
                                    input logic [63:0] a2, input logic [15:0] c,
                                    output logic [63:0] e0, output logic [63:0] e1,
                                    output logic [63:0] e2);
    logic [255:0] big, sh, back;
    logic [63:0]  win, msk;
    logic [5:0]   k;
    big  = {a0, a1, a2, 64'd0};
    sh   = big >> c;
    k    = c[5:0];
    msk  = (k == 6'd0) ? {64{1'b1}} : ~({64{1'b1}} >> k);
    win  = sh[127:64] & msk;
    back = {sh[255:192], sh[191:128], win, 64'd0} << c;
    e0 = sh[255:192];
    e1 = sh[191:128];
    e2 = win | {63'd0, |(big & ~back)};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply_chk(input string req, input logic [63:0] a0, input logic [63:0] a1,
                           input logic [63:0] a2, input logic [15:0] c);
    logic [63:0] e0, e1, e2;
    word_hi = a0; word_mid = a1; word_lo = a2; shift_amt = c;
    @(negedge clk);
    ref_model(a0, a1, a2, c, e0, e1, e2);
    check(req, $sformatf("hi  c=%0d", c), res_hi, e0);
    check(req, $sformatf("lo  c=%0d", c), res_lo, e1);
    check(req, $sformatf("ext c=%0d", c), res_extra, e2);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    word_hi = 64'hFFFF_0000_1234_5678; word_mid = 64'h1; word_lo = 64'h2; shift_amt = 16'd3;
    repeat (3) @(negedge clk);
    check("R9", "reset hi",  res_hi,    64'd0);
    check("R9", "reset lo",  res_lo,    64'd0);
    check("R9", "reset ext", res_extra, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_zero;
    apply_chk("R1", 64'hDEAD_BEEF_0123_4567, 64'h89AB_CDEF_FEDC_BA98, 64'h0000_0000_0000_0002, 16'd0);
    check("R1", "ext literal", res_extra, 64'h2);
  endtask

  task automatic t_small;
    apply_chk("R2", 64'h8000_0000_0000_0001, 64'd0, 64'd0, 16'd1);
    check("R2", "lo literal", res_lo, 64'h8000_0000_0000_0000);
    apply_chk("R2", 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'd0, 16'd17);
    apply_chk("R2", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0003, 64'd0, 16'd63);
  endtask

  task automatic t_word;
    apply_chk("R3", 64'hAAAA_5555_AAAA_5555, 64'h0000_0000_0000_0004, 64'd0, 16'd64);
    check("R3", "ext literal", res_extra, 64'h4);
    apply_chk("R3", 64'hAAAA_5555_AAAA_5555, 64'h0000_0000_0000_0004, 64'h8, 16'd64);
    check("R3", "ext sticky literal", res_extra, 64'h5);
  endtask

  task automatic t_mid;
    apply_chk("R4", 64'hF000_0000_0000_000F, 64'd0, 64'd0, 16'd65);
    apply_chk("R4", 64'h0000_0000_0000_0000, 64'h4000_0000_0000_0000, 64'd0, 16'd100);
    check("R4", "mid-only sticky", res_extra, 64'h1);
    apply_chk("R4", 64'h8000_0000_0000_0000, 64'h0, 64'h0, 16'd127);
  endtask

  task automatic t_double;
    apply_chk("R5", 64'h1234_5678_9ABC_DEF0, 64'd0, 64'd0, 16'd128);
    check("R5", "ext literal", res_extra, 64'h1234_5678_9ABC_DEF0);
    apply_chk("R5", 64'h1234_5678_9ABC_DEF0, 64'd0, 64'h100, 16'd128);
  endtask

  task automatic t_far;
    apply_chk("R6", 64'h2, 64'd0, 64'd0, 16'd129);
    check("R6", "far flag literal", res_extra, 64'h1);
    apply_chk("R6", 64'd0, 64'd0, 64'd0, 16'd129);
    apply_chk("R6", 64'd0, 64'd0, 64'h8000_0000_0000_0000, 16'd255);
    apply_chk("R6", 64'hFFFF, 64'd1, 64'd1, 16'd256);
    apply_chk("R8", 64'h1, 64'd0, 64'd0, 16'hFFFF);
    check("R8", "max count flag", res_extra, 64'h1);
    apply_chk("R8", 64'd0, 64'd0, 64'd0, 16'hFFFF);
  endtask

  task automatic t_sticky;
    apply_chk("R7", 64'd0, 64'd0, 64'h10, 16'd1);
    check("R7", "low-only sticky", res_extra, 64'h1);
    apply_chk("R7", 64'd0, 64'h2, 64'd0, 16'd1);
    check("R7", "no sticky", res_extra, 64'h0);
    apply_chk("R7", 64'd0, 64'h1, 64'h1, 16'd1);
    check("R7", "bit0 only", res_extra, 64'h8000_0000_0000_0001);
  endtask

  task automatic t_random;
    for (int i = 0; i < 60; i++) begin
      logic [15:0] c;
      c = (i % 10 == 9) ? 16'($urandom) : 16'($urandom_range(0, 300));
      apply_chk("R8", {$urandom, $urandom}, {$urandom, $urandom},
                (i % 3 == 0) ? 64'd0 : {$urandom, $urandom}, c);
    end
  endtask

  task automatic t_pipeline;
    logic [63:0] e0, e1, e2;
    logic        have;
    have = 1'b0;
    for (int i = 0; i < 8; i++) begin
      logic [63:0] a0, a1, a2;
      logic [15:0] c;
      if (have) begin
        check("R9", "pipe hi",  res_hi,    e0);
        check("R9", "pipe lo",  res_lo,    e1);
        check("R9", "pipe ext", res_extra, e2);
      end
      a0 = {$urandom, $urandom}; a1 = {$urandom, $urandom}; a2 = {$urandom, $urandom};
      c  = 16'(i * 33);
      word_hi = a0; word_mid = a1; word_lo = a2; shift_amt = c;
      ref_model(a0, a1, a2, c, e0, e1, e2);
      have = 1'b1;
      @(negedge clk);
    end
    check("R9", "pipe hi last",  res_hi,    e0);
    check("R9", "pipe ext last", res_extra, e2);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    clk = 1'b0;
    @(negedge clk);
    t_reset;
    t_zero;
    t_small;
    t_word;
    t_mid;
    t_double;
    t_far;
    t_sticky;
    t_random;
    t_pipeline;
    report;
  end

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report;
  end
endmodule